// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block is the master side of an asynchronous bus. It accepts a cycle request carrying an address, a direction and a transfer size. It then walks the bus through states S0 to S5 and drives the address strobe low from S1 through S4. The slave answers on three active-low inputs: acknowledge, bus error and halt. Each input first passes through a two-flop synchronizer.

The controller takes a first sample in S2, which it holds until acknowledge or bus error shows up. It takes a second sample two clocks later, in S4. The pair of samples picks one of four outcomes: normal, normal followed by a stop, bus error, or retry. On a stop or a retry the controller stalls and shows a halted status until halt is released. A retry then re-runs the same cycle. A built-in bus monitor turns a silent slave into a bus error.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, `as_n` is 1, `term_valid`, `berr_req`, `retry_req` and `halted` are 0, and `cyc_ready` is 1.
- R2: An accepted request drives `as_n` low for a contiguous stretch. `bus_addr`, `bus_write` and `bus_size` hold the request's values and stay stable for that whole stretch.
- R3: Acknowledge at the first sample, with neither bus error nor halt there and no bus error at the second sample, gives `term_code` 0 (normal). Neither `berr_req` nor `retry_req` is raised.
- R4: Acknowledge and halt together at the first sample, with no bus error in either sample, gives `term_code` 1 (stop). After that, `halted` is 1 and `cyc_ready` is 0 until halt is released. While halted, a request has no effect and `as_n` stays 1.
- R5: Bus error without halt at the first sample gives `term_code` 2 (bus error) with `berr_req` raised, whatever acknowledge shows.
- R6: Acknowledge alone at the first sample, followed by bus error without halt at the second sample (two clocks later), gives `term_code` 2 with `berr_req`.
- R7: Bus error and halt together at the first sample give `term_code` 3 (retry) with `retry_req`. The block then stays halted until halt is released and re-runs the cycle with the same address, direction and size.
- R8: Acknowledge alone at the first sample, followed by bus error and halt at the second sample, gives `term_code` 3 with `retry_req`.
- R9: If acknowledge is still asserted when a new cycle starts, that cycle ends at its first sample point. `term_valid` appears no more than 6 clocks after the request is accepted.
- R10: If neither acknowledge nor bus error arrives within `TMO_CYC` clocks of the strobe going low, the cycle ends with `term_code` 2 and `berr_req`. An acknowledge seen at the same sample point wins over the expiry.
- R11: `term_valid` is a one-clock pulse. `berr_req` and `retry_req` occur only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Request a bus cycle (taken while `cyc_ready`) |
| cyc_addr | input | ADDR_W | Request address |
| cyc_write | input | 1 | Request direction, 1 = write |
| cyc_size | input | 2 | Request transfer size |
| ack_n | input | 1 | Slave acknowledge, active low |
| berr_n | input | 1 | Slave bus error, active low |
| halt_n | input | 1 | Halt, active low |
| cyc_ready | output | 1 | Idle and able to take a request |
| as_n | output | 1 | Address strobe, active low |
| bus_addr | output | ADDR_W | Latched cycle address |
| bus_write | output | 1 | Latched direction |
| bus_size | output | 2 | Latched size |
| term_valid | output | 1 | One-clock pulse marking the outcome |
| term_code | output | 2 | 0 normal, 1 stop, 2 bus error, 3 retry |
| berr_req | output | 1 | Bus-error exception request |
| retry_req | output | 1 | Retry request |
| halted | output | 1 | Stalled waiting for halt release |

## Verification
Bus error and halt can land in the same sample. The block must then choose retry over a plain bus error, whether both come at the first sample or arrive together at the second after an acknowledge. The bench provokes this with directed patterns and with seeded random pairs of sample patterns. It compares each `term_code` and request pulse against a bench function that encodes the outcome rules. A separate directed case has the bus monitor run out with no answer, and the bench checks that the expiry still yields a bus error within a bounded number of clocks.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        TERM_NORMAL = 2'd0,
        TERM_HALT   = 2'd1,
        TERM_BERR   = 2'd2,
        TERM_RETRY  = 2'd3
    } term_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_HOLD
    } bus_st_e;

    // active-high view of the three slave lines
    typedef struct packed {
        logic halt;
        logic berr;
        logic ack;
    } strb_t;

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
    parameter int WIDTH = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                sync_q <= RST_VAL;
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
            end
        end
        assign dout[i] = sync_q;
    end
endmodule

// File: rtl/bt_monitor.sv
module bt_monitor #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_on,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!strobe_on)         cnt_d = '0;
        else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = strobe_on && (cnt_q >= LIMIT);

    // R10
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/bt_decode.sv
module bt_decode
    import bus_term_pkg::*;
(
    input  strb_t smp_n,
    input  strb_t smp_n2,
    output term_e code
);
    always_comb begin
        if (smp_n.berr)
            code = smp_n.halt ? TERM_RETRY : TERM_BERR;
        else if (smp_n2.berr)
            code = smp_n2.halt ? TERM_RETRY : TERM_BERR;
        else if (smp_n.halt)
            code = TERM_HALT;
        else
            code = TERM_NORMAL;
    end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bus_term_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int TMO_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    input  logic              ack_n,
    input  logic              berr_n,
    input  logic              halt_n,
    output logic              cyc_ready,
    output logic              as_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [1:0]        bus_size,
    output logic              term_valid,
    output logic [1:0]        term_code,
    output logic              berr_req,
    output logic              retry_req,
    output logic              halted
);
    typedef struct packed {
        bus_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [1:0]        size;
        strb_t             smp;
        term_e             code;
        logic              tv;
        logic              berr_rq;
        logic              retry_rq;
        logic              again;
    } ctl_t;

    ctl_t  d, q;
    logic  [2:0] syn_n;
    strb_t syn;
    logic  strobe_on, expired;
    term_e dec_code;

    bt_sync #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({halt_n, berr_n, ack_n}),
        .dout (syn_n)
    );
    assign syn = ~syn_n;

    assign strobe_on = (q.st == ST_S1) || (q.st == ST_S2) ||
                       (q.st == ST_S3) || (q.st == ST_S4);

    bt_monitor #(.TMO_CYC(TMO_CYC)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_on(strobe_on),
        .expired  (expired)
    );

    bt_decode u_dec (
        .smp_n (q.smp),
        .smp_n2(syn),
        .code  (dec_code)
    );

    always_comb begin
        d          = q;
        d.tv       = 1'b0;
        d.berr_rq  = 1'b0;
        d.retry_rq = 1'b0;
        case (q.st)
            ST_IDLE: if (cyc_start) begin
                d.addr = cyc_addr;
                d.wr   = cyc_write;
                d.size = cyc_size;
                d.st   = ST_S0;
            end
            ST_S0: begin
                d.again = 1'b0;
                d.st    = ST_S1;
            end
            ST_S1: d.st = ST_S2;
            ST_S2: if (syn.ack || syn.berr || expired) begin
                d.smp.ack  = syn.ack;
                d.smp.berr = syn.berr || (expired && !syn.ack);
                d.smp.halt = syn.halt;
                d.st       = ST_S3;
            end
            ST_S3: d.st = ST_S4;
            ST_S4: begin
                d.code     = dec_code;
                d.tv       = 1'b1;
                d.berr_rq  = (dec_code == TERM_BERR);
                d.retry_rq = (dec_code == TERM_RETRY);
                d.again    = (dec_code == TERM_RETRY);
                d.st       = ST_S5;
            end
            ST_S5: d.st = ((q.code == TERM_HALT) || (q.code == TERM_RETRY))
                          ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!syn.halt) d.st = q.again ? ST_S0 : ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.code <= TERM_NORMAL;
        end else begin
            q <= d;
        end
    end

    assign cyc_ready  = (q.st == ST_IDLE);
    assign as_n       = !strobe_on;
    assign bus_addr   = q.addr;
    assign bus_write  = q.wr;
    assign bus_size   = q.size;
    assign term_valid = q.tv;
    assign term_code  = q.code;
    assign berr_req   = q.berr_rq;
    assign retry_req  = q.retry_rq;
    assign halted     = (q.st == ST_HOLD);

    // R11
    term_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_valid |=> !term_valid);
    // R5
    berr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_req |-> (term_valid && term_code == TERM_BERR));
    // R7
    retry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> (term_valid && term_code == TERM_RETRY));
    // R4
    halted_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> as_n);
    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> ($stable(bus_addr) && $stable(bus_write)
                                     && $stable(bus_size)));
endmodule

// File: tb/bus_term_ctrl_tb_top.sv
module bus_term_ctrl_tb_top;
    localparam int AW  = 24;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic cyc_write = 1'b0;
    logic [1:0] cyc_size = 2'd0;
    logic ack_n = 1'b1, berr_n = 1'b1, halt_n = 1'b1;
    logic cyc_ready, as_n, bus_write, term_valid, berr_req, retry_req, halted;
    logic [AW-1:0] bus_addr;
    logic [1:0] bus_size, term_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_term_ctrl #(.ADDR_W(AW), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .cyc_size(cyc_size), .ack_n(ack_n),
        .berr_n(berr_n), .halt_n(halt_n), .cyc_ready(cyc_ready), .as_n(as_n),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
        .term_valid(term_valid), .term_code(term_code), .berr_req(berr_req),
        .retry_req(retry_req), .halted(halted)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pattern bits: [2]=halt [1]=berr [0]=ack, active high
    function automatic int exp_term(input logic [2:0] p1, input logic [2:0] p2);
        if (p1[1]) return p1[2] ? 3 : 2;
        if (p2[1]) return p2[2] ? 3 : 2;
        if (p1[2]) return 1;
        return 0;
    endfunction

    task automatic drive(input logic [2:0] p);
        ack_n  = !p[0];
        berr_n = !p[1];
        halt_n = !p[2];
    endtask

    task automatic start_cyc(input logic [AW-1:0] a, input logic w, input logic [1:0] s);
        cyc_addr = a; cyc_write = w; cyc_size = s; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic wait_as(output int n);
        n = 0;
        while (as_n && n < 20) begin @(negedge clk); n++; end
    endtask

    task automatic wait_term(input int lim, output int n);
        n = 0;
        while (!term_valid && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic run_case(input logic [2:0] p1, input logic [2:0] p2, input string tag);
        int e, n;
        logic [AW-1:0] sa;
        logic sw;
        logic [1:0] ss;
        e  = exp_term(p1, p2);
        sa = AW'($urandom);
        sw = 1'($urandom);
        ss = 2'($urandom);
        start_cyc(sa, sw, ss);
        wait_as(n);
        chk(!as_n && bus_addr == sa && bus_write == sw && bus_size == ss,
            "R2 strobe/addr", int'(bus_addr[15:0]), int'(sa[15:0]));
        repeat (2) @(negedge clk);
        drive(p1);
        repeat (2) @(negedge clk);
        drive(p2);
        wait_term(15, n);
        chk(term_valid == 1'b1, {tag, " term_valid"}, term_valid, 1);
        chk(int'(term_code) == e, {tag, " term_code"}, term_code, e);
        chk(berr_req == (e == 2) && retry_req == (e == 3), {tag, " R11 req pulses"},
            {berr_req, retry_req}, {e == 2, e == 3});
        @(negedge clk);
        chk(!term_valid, "R11 term pulse width", term_valid, 0);
        if (e == 1 || e == 3) begin
            @(negedge clk);
            chk(halted && !cyc_ready, {tag, " R4 halted"}, {halted, cyc_ready}, 2);
            cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
            repeat (2) @(negedge clk);
            chk(as_n && halted, {tag, " R4 start ignored while halted"}, {as_n, halted}, 3);
            drive(3'b000);
            if (e == 3) begin
                wait_as(n);
                chk(!as_n && bus_addr == sa && bus_write == sw && bus_size == ss,
                    "R7 retry reuses cycle", int'(bus_addr[15:0]), int'(sa[15:0]));
                repeat (2) @(negedge clk);
                drive(3'b001);
                wait_term(15, n);
                chk(term_valid && term_code == 2'd0, "R7 rerun normal end", term_code, 0);
            end
        end
        drive(3'b000);
        repeat (5) @(negedge clk);
        chk(!halted && cyc_ready, {tag, " back to idle"}, {halted, cyc_ready}, 1);
    endtask

    initial begin
        int n;
        logic [2:0] p1, p2;
        void'($urandom(32'd20250601));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(as_n && !term_valid && !berr_req && !retry_req && !halted && cyc_ready,
            "R1 reset outputs", {as_n, term_valid, berr_req, retry_req, halted, cyc_ready}, 6'b100001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(3'b001, 3'b000, "R3 normal");
        run_case(3'b001, 3'b100, "R3 normal halt late");
        run_case(3'b101, 3'b100, "R4 stop");
        run_case(3'b010, 3'b000, "R5 berr");
        run_case(3'b011, 3'b010, "R5 berr with ack");
        run_case(3'b001, 3'b010, "R6 ack then berr");
        run_case(3'b110, 3'b110, "R7 retry");
        run_case(3'b111, 3'b100, "R7 retry with ack");
        run_case(3'b001, 3'b110, "R8 ack then retry");

        // R9 leftover acknowledge ends next cycle early
        drive(3'b001);
        repeat (3) @(negedge clk);
        start_cyc(AW'(24'h123456), 1'b0, 2'd1);
        wait_term(12, n);
        chk(term_valid && term_code == 2'd0 && (n + 1) <= 6, "R9 early end",
            n + 1, 6);
        drive(3'b000);
        repeat (5) @(negedge clk);

        // R10 monitor expiry
        start_cyc(AW'(24'h00beef), 1'b1, 2'd2);
        wait_term(TMO + 20, n);
        chk(term_valid && term_code == 2'd2 && berr_req, "R10 timeout berr",
            term_code, 2);
        chk(n >= TMO && n <= TMO + 10, "R10 timeout window", n, TMO);
        repeat (5) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            do p1 = 3'($urandom); while (p1[1:0] == 2'b00);
            p2 = 3'($urandom);
            if (p1[2]) p2[2] = 1'b1;
            run_case(p1, p2, "R3-random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule